// File: doc/BRIEF.md
# Channel Break-In Routine Sequencer

This block lets an I/O channel borrow processor cycles to run short service routines. The channel raises a service request. Priority logic outside the block returns a grant. The sequencer then latches a routine-received condition and breaks into the processor. It saves the processor's control address, loads the routine length and steps through the routine one cycle at a time. Each routine cycle spans a fixed number of clock sub-phases.

On the final cycle of a routine, a chain input is sampled. If it is high, the sequencer starts another routine at once and never hands control back in between. If it is low, the sequencer enters a one-clock break-out state and presents the saved control address so the processor can resume where it stopped. Throughout this, the sequencer drives these outputs:
- per-cycle phase flags for routine start, chained start, chaining and last cycle;
- gated local-store read and write strobes;
- a byte-enable mask register that the datapath uses for storage writes;
- a check flag that confirms each routine actually opened with a first cycle.

Top module: `chan_brkin_seq`

## Requirements
- R1: When idle, a clock edge that samples `svc_req` and `svc_grant` both high raises `rtne_rcvd` for exactly the following clock. A request without a grant leaves `rtne_rcvd` low.
- R2: `break_in` is high for exactly one clock, the clock right after `rtne_rcvd`. At that point `ctl_addr_in` is captured.
- R3: `io_rtn` starts the clock after `break_in`. It stays high without a gap for SUB clocks per routine cycle, across every routine in a chain.
- R4: During a routine's first cycle, `first_cyc` is high for all SUB clocks and `early_first` is high only in sub-phase 0. A `rtn_len` of 0 runs as a one-cycle routine.
- R5: During a routine's last cycle, `chain` equals `chain_req` and `last_cyc` equals its inverse. The two are never high together.
- R6: When `chain_req` is high at the final clock of a last cycle, the next routine starts on the next clock with `chain_first` high for its whole first cycle. `break_out` does not assert between the two routines.
- R7: After a last cycle that ends with `chain_req` low, `break_out` is high for exactly one clock. During that clock `restore_addr` equals the address captured at break-in, even if `ctl_addr_in` has changed since.
- R8: `sbc_mask` (bit i enables storage byte lane i) resets to 0. It loads `sbc_val` on a clock edge where `sbc_load` and `io_rtn` are both high. A load request outside a routine leaves it unchanged.
- R9: `first_chk_err` pulses if the cycle after a routine load does not show `first_cyc`. In correct operation it stays low.
- R10: `ls_rd` and `ls_wr` follow `ls_rd_req` and `ls_wr_req` only while `io_rtn` is high, and are low otherwise. `ls_conflict` is high whenever both requests are high during a routine.
- R11: While reset is asserted and after it is released, all flags and strobes are 0 and `sbc_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_req | input | 1 | Channel service request |
| svc_grant | input | 1 | Grant from external priority logic |
| rtn_len | input | LENW | Routine length in cycles, loaded at each routine start |
| chain_req | input | 1 | Another routine follows the current one |
| ctl_addr_in | input | AW | Processor control address to save |
| ls_rd_req | input | 1 | Local-store read request from the routine |
| ls_wr_req | input | 1 | Local-store write request from the routine |
| sbc_load | input | 1 | Load request for the byte-control mask |
| sbc_val | input | BYTES | New byte-control mask value |
| rtne_rcvd | output | 1 | Routine-received flag |
| break_in | output | 1 | Break-in state |
| io_rtn | output | 1 | An I/O routine is running |
| early_first | output | 1 | Sub-phase 0 of a routine's first cycle |
| first_cyc | output | 1 | First cycle of any routine |
| chain_first | output | 1 | First cycle of a chained routine |
| chain | output | 1 | Last cycle, chaining follows |
| last_cyc | output | 1 | Last cycle, no chaining |
| break_out | output | 1 | Break-out state, processor restore |
| restore_addr | output | AW | Saved control address for restore |
| ls_rd | output | 1 | Gated local-store read strobe |
| ls_wr | output | 1 | Gated local-store write strobe |
| ls_conflict | output | 1 | Read and write requested together in a routine |
| sbc_mask | output | BYTES | Storage byte-enable mask |
| first_chk_err | output | 1 | First-cycle check failure |

## Verification
The bench focuses on the corner cases listed below, and each one targets a specific design mistake.

- **Zero-length and one-cycle routines.** Here the first cycle is also the last. A design that decrements before checking would run 16 cycles or skip the first-cycle flags.
- **Back-to-back chains of one-cycle routines.** A design that drops through break-out between routines, or that fails to restart with `chain_first`, shows the wrong flag counts or a stray `break_out`.
- **Changing the control address after break-in.** This exposes a design that forwards the live address instead of the saved one.
- **Mask loads and local-store requests outside a routine.** A design that gates these on the wrong state would corrupt the mask or leak strobes.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RCVD   = 3'd1,
    ST_BRKIN  = 3'd2,
    ST_RUN    = 3'd3,
    ST_BRKOUT = 3'd4
  } cbs_state_t;

endpackage

// File: rtl/cbs_cyc_ctr.sv
// Routine cycle counter: remaining cycles plus sub-phase within a cycle.
module cbs_cyc_ctr #(
  parameter int LENW = 4,
  parameter int SUB  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic [LENW-1:0] len,
  output logic            first,
  output logic            last,
  output logic            cyc_end,
  output logic            sub_zero
);

  localparam int SW = (SUB > 1) ? $clog2(SUB) : 1;
  localparam logic [SW-1:0]   SUB_LAST = SW'(SUB - 1);
  localparam logic [LENW-1:0] ONE      = LENW'(1);

  logic [LENW-1:0] rem_q, rem_d;
  logic [SW-1:0]   sub_q, sub_d;
  logic            first_q, first_d;

  always_comb begin
    rem_d   = rem_q;
    sub_d   = sub_q;
    first_d = first_q;
    if (load) begin
      rem_d   = (len == '0) ? ONE : len;
      sub_d   = '0;
      first_d = 1'b1;
    end else if (adv) begin
      if (sub_q == SUB_LAST) begin
        sub_d   = '0;
        first_d = 1'b0;
        if (rem_q > ONE) begin
          rem_d = rem_q - ONE;
        end
      end else begin
        sub_d = sub_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= ONE;
      sub_q   <= '0;
      first_q <= 1'b0;
    end else if (load || adv) begin
      rem_q   <= rem_d;
      sub_q   <= sub_d;
      first_q <= first_d;
    end
  end

  assign first    = first_q;
  assign last     = (rem_q == ONE);
  assign cyc_end  = (sub_q == SUB_LAST);
  assign sub_zero = (sub_q == '0);

endmodule

// File: rtl/cbs_fsm.sv
// Break-in / run / chain / break-out control and context save.
module cbs_fsm
  import cbs_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          svc_req,
  input  logic          svc_grant,
  input  logic          chain_req,
  input  logic [AW-1:0] ctl_addr_in,
  input  logic          ctr_first,
  input  logic          ctr_last,
  input  logic          ctr_cyc_end,
  input  logic          ctr_sub_zero,
  output logic          ctr_load,
  output logic          ctr_adv,
  output logic          rtne_rcvd,
  output logic          break_in,
  output logic          io_rtn,
  output logic          early_first,
  output logic          first_cyc,
  output logic          chain_first,
  output logic          chain,
  output logic          last_cyc,
  output logic          break_out,
  output logic [AW-1:0] restore_addr
);

  cbs_state_t state_q, state_d;
  logic       chained_q, chained_d;
  logic [AW-1:0] addr_q;
  logic       take_chain, end_rtn, addr_en;

  assign take_chain = (state_q == ST_RUN) && ctr_last && ctr_cyc_end && chain_req;
  assign end_rtn    = (state_q == ST_RUN) && ctr_last && ctr_cyc_end && !chain_req;
  assign addr_en    = (state_q == ST_BRKIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (svc_req && svc_grant) state_d = ST_RCVD;
      ST_RCVD:   state_d = ST_BRKIN;
      ST_BRKIN:  state_d = ST_RUN;
      ST_RUN:    if (end_rtn) state_d = ST_BRKOUT;
      ST_BRKOUT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    chained_d = chained_q;
    if (state_q == ST_BRKIN) begin
      chained_d = 1'b0;
    end else if (take_chain) begin
      chained_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      chained_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      chained_q <= chained_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= ctl_addr_in;
    end
  end

  assign ctr_load     = (state_q == ST_BRKIN) || take_chain;
  assign ctr_adv      = (state_q == ST_RUN);
  assign rtne_rcvd    = (state_q == ST_RCVD);
  assign break_in     = (state_q == ST_BRKIN);
  assign io_rtn       = (state_q == ST_RUN);
  assign break_out    = (state_q == ST_BRKOUT);
  assign first_cyc    = io_rtn && ctr_first;
  assign early_first  = first_cyc && ctr_sub_zero;
  assign chain_first  = first_cyc && chained_q;
  assign chain        = io_rtn && ctr_last && chain_req;
  assign last_cyc     = io_rtn && ctr_last && !chain_req;
  assign restore_addr = addr_q;

endmodule

// File: rtl/cbs_store_ctl.sv
// Local-store strobe gating and storage byte-control mask register.
module cbs_store_ctl #(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_rtn,
  input  logic             ls_rd_req,
  input  logic             ls_wr_req,
  input  logic             sbc_load,
  input  logic [BYTES-1:0] sbc_val,
  output logic             ls_rd,
  output logic             ls_wr,
  output logic             ls_conflict,
  output logic [BYTES-1:0] sbc_mask
);

  logic             lane_en;
  logic [BYTES-1:0] mask_q;

  assign lane_en = sbc_load && io_rtn;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[b] <= 1'b0;
      end else if (lane_en) begin
        mask_q[b] <= sbc_val[b];
      end
    end
  end

  assign sbc_mask    = mask_q;
  assign ls_rd       = io_rtn && ls_rd_req;
  assign ls_wr       = io_rtn && ls_wr_req;
  assign ls_conflict = io_rtn && ls_rd_req && ls_wr_req;

endmodule

// File: rtl/cbs_first_chk.sv
// Independent confirmation that every routine load is followed by a first cycle.
module cbs_first_chk (
  input  logic clk,
  input  logic rst_n,
  input  logic ctr_load,
  input  logic first_cyc,
  output logic err
);

  logic expect_q, err_q, err_d;

  assign err_d = expect_q && !first_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      expect_q <= ctr_load;
      err_q    <= err_d;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/chan_brkin_seq.sv
module chan_brkin_seq #(
  parameter int LENW  = 4,
  parameter int SUB   = 2,
  parameter int AW    = 12,
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_req,
  input  logic             svc_grant,
  input  logic [LENW-1:0]  rtn_len,
  input  logic             chain_req,
  input  logic [AW-1:0]    ctl_addr_in,
  input  logic             ls_rd_req,
  input  logic             ls_wr_req,
  input  logic             sbc_load,
  input  logic [BYTES-1:0] sbc_val,
  output logic             rtne_rcvd,
  output logic             break_in,
  output logic             io_rtn,
  output logic             early_first,
  output logic             first_cyc,
  output logic             chain_first,
  output logic             chain,
  output logic             last_cyc,
  output logic             break_out,
  output logic [AW-1:0]    restore_addr,
  output logic             ls_rd,
  output logic             ls_wr,
  output logic             ls_conflict,
  output logic [BYTES-1:0] sbc_mask,
  output logic             first_chk_err
);

  logic ctr_load, ctr_adv, ctr_first, ctr_last, ctr_cyc_end, ctr_sub_zero;

  cbs_cyc_ctr #(.LENW(LENW), .SUB(SUB)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .adv      (ctr_adv),
    .len      (rtn_len),
    .first    (ctr_first),
    .last     (ctr_last),
    .cyc_end  (ctr_cyc_end),
    .sub_zero (ctr_sub_zero)
  );

  cbs_fsm #(.AW(AW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .svc_req      (svc_req),
    .svc_grant    (svc_grant),
    .chain_req    (chain_req),
    .ctl_addr_in  (ctl_addr_in),
    .ctr_first    (ctr_first),
    .ctr_last     (ctr_last),
    .ctr_cyc_end  (ctr_cyc_end),
    .ctr_sub_zero (ctr_sub_zero),
    .ctr_load     (ctr_load),
    .ctr_adv      (ctr_adv),
    .rtne_rcvd    (rtne_rcvd),
    .break_in     (break_in),
    .io_rtn       (io_rtn),
    .early_first  (early_first),
    .first_cyc    (first_cyc),
    .chain_first  (chain_first),
    .chain        (chain),
    .last_cyc     (last_cyc),
    .break_out    (break_out),
    .restore_addr (restore_addr)
  );

  cbs_store_ctl #(.BYTES(BYTES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_rtn      (io_rtn),
    .ls_rd_req   (ls_rd_req),
    .ls_wr_req   (ls_wr_req),
    .sbc_load    (sbc_load),
    .sbc_val     (sbc_val),
    .ls_rd       (ls_rd),
    .ls_wr       (ls_wr),
    .ls_conflict (ls_conflict),
    .sbc_mask    (sbc_mask)
  );

  cbs_first_chk u_fchk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctr_load  (ctr_load),
    .first_cyc (first_cyc),
    .err       (first_chk_err)
  );

endmodule

// File: rtl/chan_brkin_seq_chk.sv
module chan_brkin_seq_chk #(
  parameter int BYTES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rtne_rcvd,
  input logic             break_in,
  input logic             io_rtn,
  input logic             early_first,
  input logic             first_cyc,
  input logic             chain_first,
  input logic             chain,
  input logic             last_cyc,
  input logic             break_out,
  input logic             ls_rd,
  input logic             ls_wr,
  input logic [BYTES-1:0] sbc_mask,
  input logic             first_chk_err
);

  p_rcvd_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rtne_rcvd |=> !rtne_rcvd);

  p_brkin_after_rcvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rtne_rcvd |=> break_in);

  p_run_after_brkin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    break_in |=> io_rtn);

  p_early_in_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    early_first |-> first_cyc);

  p_chain_last_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(chain && last_cyc));

  p_chain_first_no_brkout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chain_first |-> (io_rtn && !break_out));

  p_chain_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !$past(chain)) |-> io_rtn);

  p_brkout_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    break_out |-> ($past(last_cyc) && !io_rtn));

  p_mask_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rtn |=> $stable(sbc_mask));

  p_first_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !first_chk_err);

  p_ls_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_rd || ls_wr) |-> io_rtn);

  p_state_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rtne_rcvd, break_in, io_rtn, break_out}));

endmodule

bind chan_brkin_seq chan_brkin_seq_chk #(.BYTES(BYTES)) u_chk (.*);

// File: tb/chan_brkin_seq_bench.sv
module chan_brkin_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LENW  = 4;
  localparam int SUB   = 2;
  localparam int AW    = 12;
  localparam int BYTES = 4;

  // {len[31:28], chains[27:24], expected io clocks[23:16], addr[15:0]}
  localparam int NVEC = 7;
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd1,  4'd0, 8'd2,  16'h0123},
    {4'd3,  4'd0, 8'd6,  16'h0ABC},
    {4'd0,  4'd0, 8'd2,  16'h0F0F},
    {4'd2,  4'd1, 8'd8,  16'h0555},
    {4'd1,  4'd2, 8'd6,  16'h0777},
    {4'd4,  4'd1, 8'd16, 16'h0321},
    {4'd15, 4'd0, 8'd30, 16'h0FFE}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             svc_req, svc_grant, chain_req;
  logic [LENW-1:0]  rtn_len;
  logic [AW-1:0]    ctl_addr_in;
  logic             ls_rd_req, ls_wr_req, sbc_load;
  logic [BYTES-1:0] sbc_val;
  logic             rtne_rcvd, break_in, io_rtn, early_first, first_cyc;
  logic             chain_first, chain, last_cyc, break_out;
  logic [AW-1:0]    restore_addr;
  logic             ls_rd, ls_wr, ls_conflict;
  logic [BYTES-1:0] sbc_mask;
  logic             first_chk_err;

  int tests = 0;
  int fails = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_brkin_seq #(.LENW(LENW), .SUB(SUB), .AW(AW), .BYTES(BYTES)) u_chan_brkin_seq (
    .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .svc_grant(svc_grant),
    .rtn_len(rtn_len), .chain_req(chain_req), .ctl_addr_in(ctl_addr_in),
    .ls_rd_req(ls_rd_req), .ls_wr_req(ls_wr_req), .sbc_load(sbc_load),
    .sbc_val(sbc_val), .rtne_rcvd(rtne_rcvd), .break_in(break_in),
    .io_rtn(io_rtn), .early_first(early_first), .first_cyc(first_cyc),
    .chain_first(chain_first), .chain(chain), .last_cyc(last_cyc),
    .break_out(break_out), .restore_addr(restore_addr), .ls_rd(ls_rd),
    .ls_wr(ls_wr), .ls_conflict(ls_conflict), .sbc_mask(sbc_mask),
    .first_chk_err(first_chk_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Runs one vector; all counts are per clock sampled mid-cycle.
  task automatic run_vec(input logic [31:0] v);
    int nch, exp_io, idx, rcvd_idx, brk_idx, bo_idx, chains_done;
    int n_io, n_early, n_first, n_cf, n_chain, n_last, n_bo, n_err;
    logic [AW-1:0] addr, rest;
    rtn_len = v[31:28];
    nch     = int'(v[27:24]);
    exp_io  = int'(v[23:16]);
    addr    = v[AW-1:0];
    chains_done = 0;
    chain_req = (nch > 0);
    ctl_addr_in = addr;
    svc_req = 1'b1; svc_grant = 1'b1;
    rcvd_idx = -1; brk_idx = -1; bo_idx = -1;
    n_io = 0; n_early = 0; n_first = 0; n_cf = 0; n_chain = 0; n_last = 0; n_bo = 0; n_err = 0;
    rest = '0;
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      if (early_first && chain_first) chains_done++;
      chain_req = (chains_done < nch);
      svc_req = 1'b0; svc_grant = 1'b0;
      if (brk_idx >= 0) ctl_addr_in = ~addr;
      #1;
      idx = i;
      if (rtne_rcvd) rcvd_idx = idx;
      if (break_in) brk_idx = idx;
      if (io_rtn) n_io++;
      if (early_first) n_early++;
      if (first_cyc) n_first++;
      if (chain_first) n_cf++;
      if (chain) n_chain++;
      if (last_cyc) n_last++;
      if (first_chk_err) n_err++;
      if (break_out) begin
        n_bo++; bo_idx = idx; rest = restore_addr;
        break;
      end
    end
    tick();
    check(rcvd_idx == 1, "R1 rcvd clock", rcvd_idx, 1);
    check(brk_idx == 2, "R2 break_in clock", brk_idx, 2);
    check(n_io == exp_io, "R3 io_rtn clocks", n_io, exp_io);
    check(n_early == nch + 1, "R4 early_first count", n_early, nch + 1);
    check(n_first == SUB * (nch + 1), "R4 first_cyc clocks", n_first, SUB * (nch + 1));
    check(n_chain == SUB * nch, "R5 chain clocks", n_chain, SUB * nch);
    check(n_last == SUB, "R5 last_cyc clocks", n_last, SUB);
    check(n_cf == SUB * nch, "R6 chain_first clocks", n_cf, SUB * nch);
    check(n_bo == 1 && bo_idx == 3 + exp_io, "R7 break_out position", bo_idx, 3 + exp_io);
    check(rest == addr, "R7 restore_addr", int'(rest), int'(addr));
    check(n_err == 0, "R9 first check", n_err, 0);
    check(!io_rtn && !break_out, "R7 back to idle", int'(io_rtn), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    svc_req = 0; svc_grant = 0; chain_req = 0; rtn_len = '0; ctl_addr_in = '0;
    ls_rd_req = 0; ls_wr_req = 0; sbc_load = 0; sbc_val = '0;
    tick();
    // R11: outputs during reset
    check({rtne_rcvd, break_in, io_rtn, early_first, first_cyc, chain_first,
           chain, last_cyc, break_out, ls_rd, ls_wr, ls_conflict, first_chk_err} == '0,
          "R11 flags in reset", 1, 0);
    check(sbc_mask == '0, "R11 mask in reset", int'(sbc_mask), 0);
    tick();
    rst_n = 1'b1;
    tick();
    check(!io_rtn && !rtne_rcvd && sbc_mask == '0, "R11 idle after reset", int'(io_rtn), 0);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R1: request without grant is ignored
    svc_req = 1'b1; svc_grant = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(!rtne_rcvd && !break_in, "R1 no grant", int'(rtne_rcvd), 0);
    end
    svc_req = 1'b0;

    // R10: requests outside a routine give no strobes
    ls_rd_req = 1'b1; ls_wr_req = 1'b1;
    #1;
    check(!ls_rd && !ls_wr && !ls_conflict, "R10 idle strobes", int'({ls_rd, ls_wr}), 0);
    ls_rd_req = 1'b0; ls_wr_req = 1'b0;

    // R8: load outside a routine ignored
    sbc_load = 1'b1; sbc_val = 4'h5;
    tick();
    sbc_load = 1'b0;
    tick();
    check(sbc_mask == 4'h0, "R8 idle load ignored", int'(sbc_mask), 0);

    // Routine of 6 cycles for store tests
    rtn_len = 4'd6; chain_req = 1'b0; ctl_addr_in = 12'h111;
    @(negedge clk); svc_req = 1'b1; svc_grant = 1'b1;
    tick(); svc_req = 1'b0; svc_grant = 1'b0;  // rcvd
    tick();                                     // break_in
    tick();                                     // first run clock
    check(io_rtn, "R3 routine running", int'(io_rtn), 1);
    ls_rd_req = 1'b1; #1;
    check(ls_rd && !ls_wr && !ls_conflict, "R10 read strobe", int'({ls_rd, ls_wr, ls_conflict}), 4);
    ls_wr_req = 1'b1; #1;
    check(ls_conflict && ls_rd && ls_wr, "R10 conflict flag", int'(ls_conflict), 1);
    ls_rd_req = 1'b0; #1;
    check(ls_wr && !ls_rd && !ls_conflict, "R10 write strobe", int'({ls_rd, ls_wr, ls_conflict}), 2);
    ls_wr_req = 1'b0;
    sbc_load = 1'b1; sbc_val = 4'hA;
    tick();
    sbc_load = 1'b0;
    check(sbc_mask == 4'hA, "R8 load in routine", int'(sbc_mask), 10);
    for (int i = 0; i < 40 && !break_out; i++) tick();
    check(break_out && restore_addr == 12'h111, "R7 restore after store test", int'(restore_addr), 'h111);
    tick();
    sbc_load = 1'b1; sbc_val = 4'h3;
    tick();
    sbc_load = 1'b0;
    tick();
    check(sbc_mask == 4'hA, "R8 mask kept after routine", int'(sbc_mask), 10);
    check(!first_chk_err, "R9 no check error", int'(first_chk_err), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule